// File: doc/BRIEF.md
# Clocked-host bridge for an asynchronous byte-wide static RAM

This block lets a synchronous host read and write an external asynchronous static RAM that holds 131,072 bytes. The host raises `req_i` and presents an address, a write flag and write data. It keeps `req_i` high until it sees a one-cycle `ack_o`. For a read, `rdata_o` is valid in the cycle where `ack_o` is high. On the memory side the block drives the address bus, an active-low chip select, an active-high chip select, an output-enable strobe and a write strobe. It drives the data bus through a separate output/enable/input triple, and the tristate pad sits outside the block.

All memory timing is counted in clock cycles. The counts come from two parameters: `CLK_PERIOD_NS`, and `SPEED_GRADE_NS` set to 35, 55 or 70. Each nanosecond minimum is turned into cycles by ceiling division.

The sequencer has four states:
- ST_IDLE: standby.
- ST_SETUP: one cycle. The chip selects are asserted and the address is stable.
- ST_STROBE: the write strobe is low, or the output enable is low for a read.
- ST_RECOVER: the strobes are released while the selects are held.

The transitions are:
- ST_IDLE to ST_SETUP when a request is accepted.
- ST_SETUP to ST_STROBE after one cycle.
- ST_STROBE to ST_RECOVER when the strobe count expires.
- ST_RECOVER to ST_IDLE when the recovery count expires.

With the defaults (10 ns clock, 55 ns grade), a write uses 1 setup cycle, 4 strobe cycles and 1 recovery cycle. A read uses 1 setup cycle, 6 strobe cycles and 3 recovery cycles.

Top module: `sram_bridge`

## Requirements
- R1: While idle and after reset, the memory pins are in standby: active-low select high, active-high select low, write strobe high, output enable high, data driver enable low, and `ack_o` low.
- R2: During a write, the write strobe stays low for at least the grade's minimum pulse (40 ns at the 55 ns grade). Both chip selects stay active for the whole time the strobe is low.
- R3: The data driver enable rises only after the write strobe has been low for at least one cycle. It stays high until the write strobe has returned high. The driven data therefore leads the end of the write by at least the grade's data setup (25 ns at the 55 ns grade), with hold of at least zero.
- R4: The output enable stays high for the whole of every write.
- R5: The address and chip selects do not change while the write strobe is low.
- R6: A read holds output enable low for the address-access count (6 cycles by default). The data bus is captured on the edge that ends this count. `rdata_o` then returns the byte last written at that address.
- R7: `ack_o` is high for exactly one cycle per request. With the defaults it rises 6 cycles after the accepting edge for a write and 10 cycles after it for a read.
- R8: A new request is not accepted before the cycle after the one in which `ack_o` was high. A `req_i` still held high during `ack_o` does not start a second transfer.
- R9: Each write spans at least the grade's write-cycle time and each read at least its read-cycle time (55 ns each at the 55 ns grade). Read recovery also covers the output-disable-to-high-Z time.
- R10: Setup, strobe and recovery cycle counts are the ceiling of each nanosecond minimum divided by `CLK_PERIOD_NS`. The write strobe count is the larger of the pulse count and the data-setup count plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request, held until acknowledge |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data, valid with `ack_o` on reads |
| mem_addr_o | output | 17 | Memory address bus |
| mem_ce1_n_o | output | 1 | Active-low chip select |
| mem_ce2_o | output | 1 | Active-high chip select |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_we_n_o | output | 1 | Active-low write strobe |
| mem_dq_o | output | 8 | Data to the memory |
| mem_dq_oe_o | output | 1 | Data pad drive enable |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
The bench models a memory whose data becomes valid only after the full access time. A bridge that sampled one cycle early would therefore return a garbage pattern instead of the stored byte.

Every write-strobe rise is timed against its fall and against the rise of the driver enable. This catches a strobe that is too short, data that is driven before the strobe falls, and an address that moves inside the window. The output-enable level is also checked at that point.

The addresses used are the lowest and highest in the array, alternating-bit patterns, an overwrite and an unwritten location. Request and acknowledge latencies are counted in cycles.

A held request across the acknowledge must not start a spurious second transfer.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RECOVER = 2'd3
    } seq_state_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // minimum write strobe width per grade
    function automatic int unsigned grade_pulse_ns(input int unsigned grade);
        case (grade)
            35:      return 25;
            55:      return 40;
            default: return 45;
        endcase
    endfunction

    // minimum data-valid to end of write per grade
    function automatic int unsigned grade_dsetup_ns(input int unsigned grade);
        case (grade)
            35:      return 20;
            55:      return 25;
            default: return 30;
        endcase
    endfunction

    // worst output-disable to high impedance per grade
    function automatic int unsigned grade_release_ns(input int unsigned grade);
        case (grade)
            35:      return 25;
            55:      return 30;
            default: return 35;
        endcase
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              op_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [DATA_W-1:0] rdata_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_wr_o    <= 1'b0;
            mem_addr_o <= '0;
            mem_dq_o   <= '0;
        end else if (accept_i) begin
            op_wr_o    <= req_wr_i;
            mem_addr_o <= req_addr_i;
            mem_dq_o   <= req_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (capture_i) begin
            rdata_o <= mem_dq_i;
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_bridge_pkg::*;
#(
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned STROBE_WR  = 4,
    parameter int unsigned STROBE_RD  = 6,
    parameter int unsigned RECOVER_WR = 1,
    parameter int unsigned RECOVER_RD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             op_wr_i,
    input  logic             expired_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             accept_o,
    output logic             capture_o,
    output logic             ack_o,
    output logic             mem_ce1_n_o,
    output logic             mem_ce2_o,
    output logic             mem_oe_n_o,
    output logic             mem_we_n_o,
    output logic             mem_dq_oe_o
);

    seq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign accept_o  = (state_q == ST_IDLE) && req_i && !ack_o;
    assign capture_o = (state_q == ST_STROBE) && expired_i && !op_wr_i;

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept_o)  state_d = ST_SETUP;
            ST_SETUP:   if (expired_i) state_d = ST_STROBE;
            ST_STROBE:  if (expired_i) state_d = ST_RECOVER;
            ST_RECOVER: if (expired_i) state_d = ST_IDLE;
        endcase
    end

    // timer load on every state entry
    always_comb begin
        load_o     = (state_d != state_q);
        load_val_o = '0;
        unique case (state_d)
            ST_IDLE:    load_val_o = '0;
            ST_SETUP:   load_val_o = '0;
            ST_STROBE:  load_val_o = op_wr_i ? CNT_W'(STROBE_WR - 1) : CNT_W'(STROBE_RD - 1);
            ST_RECOVER: load_val_o = op_wr_i ? CNT_W'(RECOVER_WR - 1) : CNT_W'(RECOVER_RD - 1);
        endcase
    end

    // registered pin outputs, glitch free toward the memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce1_n_o <= 1'b1;
            mem_ce2_o   <= 1'b0;
            mem_oe_n_o  <= 1'b1;
            mem_we_n_o  <= 1'b1;
            mem_dq_oe_o <= 1'b0;
            ack_o       <= 1'b0;
        end else begin
            ack_o <= (state_q == ST_RECOVER) && expired_i;
            unique case (state_d)
                ST_IDLE: begin
                    mem_ce1_n_o <= 1'b1;
                    mem_ce2_o   <= 1'b0;
                    mem_oe_n_o  <= 1'b1;
                    mem_we_n_o  <= 1'b1;
                    mem_dq_oe_o <= 1'b0;
                end
                ST_SETUP: begin
                    mem_ce1_n_o <= 1'b0;
                    mem_ce2_o   <= 1'b1;
                    mem_oe_n_o  <= 1'b1;
                    mem_we_n_o  <= 1'b1;
                    mem_dq_oe_o <= 1'b0;
                end
                ST_STROBE: begin
                    mem_ce1_n_o <= 1'b0;
                    mem_ce2_o   <= 1'b1;
                    mem_oe_n_o  <= op_wr_i;
                    mem_we_n_o  <= !op_wr_i;
                    mem_dq_oe_o <= op_wr_i && (state_q == ST_STROBE);
                end
                ST_RECOVER: begin
                    mem_ce1_n_o <= 1'b0;
                    mem_ce2_o   <= 1'b1;
                    mem_oe_n_o  <= 1'b1;
                    mem_we_n_o  <= 1'b1;
                    mem_dq_oe_o <= op_wr_i && (state_q == ST_STROBE);
                end
            endcase
        end
    end

    // R1
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (mem_ce1_n_o && !mem_ce2_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

    // R2 R4
    we_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> (!mem_ce1_n_o && mem_ce2_o && mem_oe_n_o));

    // R3
    drive_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe_o) |-> (!mem_we_n_o && $past(!mem_we_n_o)));

    // R6
    capture_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> !mem_oe_n_o);

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R8
    ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS  = 10,
    parameter int unsigned SPEED_GRADE_NS = 55,
    parameter int unsigned ADDR_W         = 17,
    parameter int unsigned DATA_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce1_n_o,
    output logic              mem_ce2_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);

    // R10: cycle counts from nanosecond minima
    localparam int unsigned CYC_WC    = ceil_div(SPEED_GRADE_NS, CLK_PERIOD_NS);
    localparam int unsigned CYC_PULSE = ceil_div(grade_pulse_ns(SPEED_GRADE_NS), CLK_PERIOD_NS);
    localparam int unsigned CYC_DSU   = ceil_div(grade_dsetup_ns(SPEED_GRADE_NS), CLK_PERIOD_NS);
    localparam int unsigned CYC_REL   = ceil_div(grade_release_ns(SPEED_GRADE_NS), CLK_PERIOD_NS);
    localparam int unsigned STROBE_WR = max2(CYC_PULSE, CYC_DSU + 1);
    localparam int unsigned STROBE_RD = max2(CYC_WC, 1);
    localparam int unsigned RECOVER_WR = (CYC_WC > STROBE_WR + 1) ? (CYC_WC - STROBE_WR - 1) : 1;
    localparam int unsigned RECOVER_RD = max2(CYC_REL, 1);
    localparam int unsigned MAX_CNT   = max2(max2(STROBE_WR, STROBE_RD), max2(RECOVER_WR, RECOVER_RD));
    localparam int unsigned CNT_W     = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT);

    logic             op_wr;
    logic             expired;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             accept;
    logic             capture;

    sram_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .expired_o  (expired)
    );

    sram_seq_fsm #(
        .CNT_W      (CNT_W),
        .STROBE_WR  (STROBE_WR),
        .STROBE_RD  (STROBE_RD),
        .RECOVER_WR (RECOVER_WR),
        .RECOVER_RD (RECOVER_RD)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .op_wr_i     (op_wr),
        .expired_i   (expired),
        .load_o      (load),
        .load_val_o  (load_val),
        .accept_o    (accept),
        .capture_o   (capture),
        .ack_o       (ack_o),
        .mem_ce1_n_o (mem_ce1_n_o),
        .mem_ce2_o   (mem_ce2_o),
        .mem_oe_n_o  (mem_oe_n_o),
        .mem_we_n_o  (mem_we_n_o),
        .mem_dq_oe_o (mem_dq_oe_o)
    );

    sram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .capture_i   (capture),
        .req_wr_i    (req_wr_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .mem_dq_i    (mem_dq_i),
        .op_wr_o     (op_wr),
        .mem_addr_o  (mem_addr_o),
        .mem_dq_o    (mem_dq_o),
        .rdata_o     (rdata_o)
    );

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> $stable(mem_addr_o));

endmodule

// File: tb/sram_bridge_test.sv
`timescale 1ns/1ps
module sram_bridge_test;

    localparam int CLK_PERIOD_NS = 10;
    localparam int WR_LAT  = 6;
    localparam int RD_LAT  = 10;
    localparam real T_ACC  = 55.0;
    localparam real T_WP   = 40.0;
    localparam real T_DSU  = 25.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [16:0] mem_addr;
    logic        ce1_n, ce2, oe_n, we_n, dq_oe;
    logic [7:0]  dq_out;
    logic [7:0]  dq_in = 8'hEE;

    int checks = 0;
    int fails  = 0;
    int cycle  = 0;

    sram_bridge uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .req_wr_i    (req_wr),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .ack_o       (ack),
        .rdata_o     (rdata),
        .mem_addr_o  (mem_addr),
        .mem_ce1_n_o (ce1_n),
        .mem_ce2_o   (ce2),
        .mem_oe_n_o  (oe_n),
        .mem_we_n_o  (we_n),
        .mem_dq_o    (dq_out),
        .mem_dq_oe_o (dq_oe),
        .mem_dq_i    (dq_in)
    );

    always #(CLK_PERIOD_NS/2) clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem_arr [int];
    real last_chg = 0.0;
    real t_we_fall = 0.0;
    real t_drv = 0.0;
    bit  we_seen = 1'b0;
    logic [16:0] addr_at_fall = '0;

    always @(mem_addr or oe_n or ce1_n or ce2) last_chg = $realtime;

    always begin
        #1;
        if (!ce1_n && ce2 && !oe_n && we_n && ($realtime - last_chg >= T_ACC))
            dq_in = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : 8'h00;
        else
            dq_in = 8'hEE;
    end

    always @(negedge we_n) begin
        if (rst_n) begin
            t_we_fall    = $realtime;
            addr_at_fall = mem_addr;
            we_seen      = 1'b1;
        end
    end

    always @(posedge dq_oe) t_drv = $realtime;

    always @(posedge we_n) begin
        if (we_seen) begin
            we_seen = 1'b0;
            // R2: pulse width and selects
            check(($realtime - t_we_fall) >= T_WP, "R2 write pulse ns", int'($realtime - t_we_fall), int'(T_WP));
            check(!ce1_n && ce2, "R2 selects active at end of write", {ce1_n, ce2}, 2'b01);
            // R3: data driven long enough before end of write
            check(dq_oe && t_drv > t_we_fall && ($realtime - t_drv) >= T_DSU,
                  "R3 data setup ns", int'($realtime - t_drv), int'(T_DSU));
            // R4
            check(oe_n, "R4 output enable high during write", oe_n, 1);
            // R5
            check(mem_addr == addr_at_fall, "R5 address stable in window", mem_addr, addr_at_fall);
            if (!ce1_n && ce2) mem_arr[int'(mem_addr)] = dq_out;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         wr;
        logic [7:0] data;
        int         due;
    } exp_t;
    exp_t sb_q[$];
    logic [7:0] shadow [int];
    bit prev_ack = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ack && prev_ack)
                check(1'b0, "R7 ack longer than one cycle", 1, 0);
            if (ack) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8 unexpected ack", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(cycle == e.due, "R7 R9 ack latency cycle", cycle, e.due);
                    if (!e.wr)
                        check(rdata == e.data, "R6 read data", rdata, e.data);
                end
            end
            prev_ack = ack;
        end
    end

    task automatic do_req(input bit wr, input logic [16:0] addr, input logic [7:0] data, input bit hold_extra);
        exp_t e;
        e.wr   = wr;
        e.data = wr ? data : (shadow.exists(int'(addr)) ? shadow[int'(addr)] : 8'h00);
        e.due  = cycle + 1 + (wr ? WR_LAT : RD_LAT);
        if (wr) shadow[int'(addr)] = data;
        sb_q.push_back(e);
        req       = 1'b1;
        req_wr    = wr;
        req_addr  = addr;
        req_wdata = data;
        do @(negedge clk); while (!ack);
        if (hold_extra) @(negedge clk);
        req = 1'b0;
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * CLK_PERIOD_NS);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R1: standby during and after reset
        check(ce1_n && !ce2 && we_n && oe_n && !dq_oe && !ack, "R1 reset standby",
              {ce1_n, ce2, we_n, oe_n, dq_oe, ack}, 6'b101100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ce1_n && !ce2 && !dq_oe, "R1 idle standby", {ce1_n, ce2, dq_oe}, 3'b100);

        do_req(1'b1, 17'h00000, 8'hA5, 1'b0);
        do_req(1'b1, 17'h1FFFF, 8'h5A, 1'b0);
        do_req(1'b1, 17'h0AAAA, 8'h3C, 1'b0);
        do_req(1'b1, 17'h15555, 8'hC3, 1'b0);
        check(ce1_n && !ce2 && we_n && oe_n && !dq_oe, "R1 standby between transfers",
              {ce1_n, ce2, we_n, oe_n, dq_oe}, 5'b10110);
        do_req(1'b0, 17'h00000, 8'h00, 1'b0);
        do_req(1'b0, 17'h1FFFF, 8'h00, 1'b0);
        do_req(1'b0, 17'h0AAAA, 8'h00, 1'b0);
        do_req(1'b0, 17'h15555, 8'h00, 1'b0);
        do_req(1'b1, 17'h00000, 8'hFF, 1'b0);
        do_req(1'b0, 17'h00000, 8'h00, 1'b0);
        do_req(1'b0, 17'h01234, 8'h00, 1'b0);

        for (int i = 0; i < 8; i++) begin
            logic [16:0] a;
            a = 17'(i * 16411 + 7);
            do_req(1'b1, a, 8'(i * 37 + 11), 1'b0);
            do_req(1'b0, a, 8'h00, 1'b0);
        end

        // R8: request held high through the acknowledge cycle
        do_req(1'b1, 17'h00777, 8'h69, 1'b1);
        repeat (15) @(negedge clk);
        check(sb_q.size() == 0, "R8 no second transfer", sb_q.size(), 0);
        check(ce1_n && !ce2 && we_n, "R8 bus stays standby", {ce1_n, ce2, we_n}, 3'b101);
        do_req(1'b0, 17'h00777, 8'h00, 1'b0);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R7 every request acknowledged", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule